// File: doc/BRIEF.md
# Storage-to-Storage Byte String Engine

This block runs one byte-string instruction at a time against a byte-wide memory port. A 48-bit instruction word is presented with a start pulse. The block resolves two operand addresses through a 16-entry base register lookup and then walks both strings one byte at a time. It either copies the second string over the first, or compares the two strings and reports a 2-bit condition code.

The instruction word is laid out from bit 47 down:

| Bits | Field |
|---|---|
| 47:40 | opcode |
| 39:32 | length minus one |
| 31:28 | first base selector |
| 27:16 | first displacement |
| 15:12 | second base selector |
| 11:0 | second displacement |

Each operand address is the selected base register plus the zero-extended displacement, kept to 24 bits. The memory port returns read data one cycle after a read strobe. The block is used as a memory-to-memory helper beside a core: the core hands over the instruction and waits for the completion pulse.

Top module: `str_op_engine`

## Requirements
- R1: Opcode 8'h01 selects the move and opcode 8'h02 selects the compare. A start with any other opcode is ignored: busy stays low and no memory access is made.
- R2: An operand address is the low 24 bits of the selected base register plus the 12-bit displacement. The displacement occupies bits 27:16 for the first operand and bits 11:0 for the second. A selector of 0 contributes zero, whatever register 0 holds.
- R3: A length field of value L (bits 39:32) processes L+1 bytes: 0 means one byte and 255 means 256 bytes.
- R4: The move copies bytes from the second operand to the first operand in ascending address order, one byte per step. When the destination starts one byte above the source, the first source byte is repeated through the destination.
- R5: The compare stops at the first unequal byte pair and sets the condition code by unsigned value: 0 when all bytes are equal, 1 when the first operand byte is lower, 2 when it is higher. After the mismatch no further memory read is made.
- R6: A move leaves the condition code unchanged.
- R7: done is a single-cycle pulse that ends each accepted instruction. busy is high from the cycle after an accepted start until done. A start while busy is ignored.
- R8: Read data is taken one cycle after the read strobe. A read and a write never occur in the same cycle, and every write follows a read in the previous cycle.
- R9: Operand addresses advance modulo 2^24, so a string that crosses 24'hFFFFFF continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the instruction on instr |
| instr | input | 48 | Instruction word |
| regSel | output | 4 | Base register index being looked up |
| regData | input | 32 | Contents of the register at regSel, same cycle |
| memAddr | output | 24 | Memory byte address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after memRd |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code |

## Verification
A wrong byte counter or a wrong pointer shows at the ports within one byte step. It appears as a read or write to the wrong address, or as an extra or missing read that the bench counts per instruction. A stale byte latch in the compare path first shows as a wrong condition code at the done pulse. It also shows as a wrong number of reads before done, because the compare stops at the mismatch. Address truncation and wrap faults appear on the logged read addresses as soon as a string crosses the 24-bit boundary.

// File: rtl/str_op_pkg.sv
package str_op_pkg;
  localparam int INSTR_W = 48;
  localparam int OPC_W   = 8;
  localparam int LEN_W   = 8;
  localparam int SEL_W   = 4;
  localparam int DISP_W  = 12;
  localparam int REG_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int CC_W    = 2;

  localparam logic [OPC_W-1:0] OPC_MOVE = 8'h01;
  localparam logic [OPC_W-1:0] OPC_CMP  = 8'h02;

  localparam logic [CC_W-1:0] CC_EQUAL = 2'd0;
  localparam logic [CC_W-1:0] CC_LOWER = 2'd1;
  localparam logic [CC_W-1:0] CC_HIGHER = 2'd2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic ldA;
    logic ldB;
    logic rdA;
    logic rdB;
    logic write;
    logic compare;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/str_op_ctrl.sv
module str_op_ctrl
  import str_op_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    validOp,
  input  logic    isMove,
  input  logic    lastByte,
  input  logic    mismatch,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  typedef enum logic [2:0] {
    S_IDLE, S_BASEA, S_BASEB, S_RDA, S_RDB, S_ACT, S_FIN
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (start && validOp) begin
        strb.capture = 1'b1;
        stateNext    = S_BASEA;
      end
      S_BASEA: begin
        strb.ldA  = 1'b1;
        stateNext = S_BASEB;
      end
      S_BASEB: begin
        strb.ldB  = 1'b1;
        stateNext = isMove ? S_RDB : S_RDA;
      end
      S_RDA: begin
        strb.rdA  = 1'b1;
        stateNext = S_RDB;
      end
      S_RDB: begin
        strb.rdB  = 1'b1;
        stateNext = S_ACT;
      end
      S_ACT: begin
        if (isMove) begin
          strb.write = 1'b1;
          if (lastByte) stateNext = S_FIN;
          else begin
            strb.advance = 1'b1;
            stateNext    = S_RDB;
          end
        end else begin
          strb.compare = 1'b1;
          if (mismatch || lastByte) stateNext = S_FIN;
          else begin
            strb.advance = 1'b1;
            stateNext    = S_RDA;
          end
        end
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/str_op_dp.sv
module str_op_dp
  import str_op_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  strobe_t            strb,
  output logic [SEL_W-1:0]   regSel,
  input  logic [REG_W-1:0]   regData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRd,
  output logic               memWr,
  output logic [BYTE_W-1:0]  memWdata,
  input  logic [BYTE_W-1:0]  memRdata,
  output logic [CC_W-1:0]    cc,
  output logic               validOp,
  output logic               isMove,
  output logic               lastByte,
  output logic               mismatch
);
  localparam int OPC_LO = INSTR_W - OPC_W;
  localparam int LEN_LO = OPC_LO - LEN_W;
  localparam int SA_LO  = LEN_LO - SEL_W;
  localparam int DA_LO  = SA_LO - DISP_W;
  localparam int SB_LO  = DA_LO - SEL_W;

  logic [INSTR_W-1:0] instrQ;
  logic [ADDR_W-1:0]  addrA, addrB;
  logic [LEN_W-1:0]   remain;
  logic [BYTE_W-1:0]  byteA;
  logic [DISP_W-1:0]  disp;
  logic [ADDR_W-1:0]  baseVal, effAddr;
  logic [OPC_W-1:0]   opIn;

  assign opIn    = instr[INSTR_W-1 -: OPC_W];
  assign validOp = (opIn == OPC_MOVE) || (opIn == OPC_CMP);
  assign isMove  = (instrQ[INSTR_W-1 -: OPC_W] == OPC_MOVE);

  assign regSel  = strb.ldB ? instrQ[SB_LO +: SEL_W] : instrQ[SA_LO +: SEL_W];
  assign disp    = strb.ldB ? instrQ[0 +: DISP_W]    : instrQ[DA_LO +: DISP_W];
  assign baseVal = (regSel == '0) ? '0 : regData[ADDR_W-1:0];
  assign effAddr = baseVal + ADDR_W'(disp);

  assign lastByte = (remain == '0);
  assign mismatch = (memRdata != byteA);

  assign memRd    = strb.rdA | strb.rdB;
  assign memWr    = strb.write;
  assign memAddr  = strb.rdB ? addrB : addrA;
  assign memWdata = memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      addrA  <= '0;
      addrB  <= '0;
      remain <= '0;
      byteA  <= '0;
      cc     <= CC_EQUAL;
    end else begin
      if (strb.capture) begin
        instrQ <= instr;
        remain <= instr[LEN_LO +: LEN_W];
      end
      if (strb.ldA) addrA <= effAddr;
      if (strb.ldB) addrB <= effAddr;
      if (strb.rdB) byteA <= memRdata;
      if (strb.compare) begin
        if (mismatch)      cc <= (byteA < memRdata) ? CC_LOWER : CC_HIGHER;
        else if (lastByte) cc <= CC_EQUAL;
      end
      if (strb.advance) begin
        addrA  <= addrA + 1'b1;
        addrB  <= addrB + 1'b1;
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/str_op_engine.sv
module str_op_engine
  import str_op_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  output logic [SEL_W-1:0]   regSel,
  input  logic [REG_W-1:0]   regData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               memRd,
  output logic               memWr,
  output logic [BYTE_W-1:0]  memWdata,
  input  logic [BYTE_W-1:0]  memRdata,
  output logic               busy,
  output logic               done,
  output logic [CC_W-1:0]    cc
);
  strobe_t strb;
  logic validOp, isMove, lastByte, mismatch;

  str_op_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .validOp(validOp),
    .isMove(isMove), .lastByte(lastByte), .mismatch(mismatch),
    .strb(strb), .busy(busy), .done(done)
  );

  str_op_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .instr(instr), .strb(strb),
    .regSel(regSel), .regData(regData), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .cc(cc), .validOp(validOp),
    .isMove(isMove), .lastByte(lastByte), .mismatch(mismatch)
  );
endmodule

// File: rtl/str_op_chk.sv
module str_op_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       memRd,
  input logic       memWr,
  input logic [1:0] cc
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !memWr));

  p_cc_at_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cc) |-> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  p_no_rw_clash_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd));
endmodule

bind str_op_engine str_op_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .memRd(memRd), .memWr(memWr), .cc(cc)
);

// File: tb/tb_str_op_engine.sv
module tb_str_op_engine;
  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [47:0] instr;
  logic [3:0]  regSel;
  logic [31:0] regData;
  logic [23:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWdata, memRdata;
  logic        busy, done;
  logic [1:0]  cc;

  always #10 clk = ~clk;

  str_op_engine dut (.*);

  logic [31:0] regFile [0:15];
  assign regData = regFile[regSel];

  logic [7:0]  mem [0:4095];
  logic [23:0] rdLog [0:63];
  int          rdCount = 0;
  int          doneCount = 0;
  int          clashCount = 0;
  logic        tbWe = 1'b0;
  logic [11:0] tbA = '0;
  logic [7:0]  tbD = '0;

  always @(posedge clk) begin
    if (tbWe) mem[tbA] <= tbD;
    if (memRd) begin
      memRdata <= mem[memAddr[11:0]];
      rdLog[rdCount[5:0]] <= memAddr;
      rdCount <= rdCount + 1;
    end
    if (memWr) mem[memAddr[11:0]] <= memWdata;
    if (done) doneCount <= doneCount + 1;
    if (memRd && memWr) clashCount <= clashCount + 1;
  end

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [7:0] op, input logic [7:0] len,
      input logic [3:0] b1, input logic [11:0] d1, input logic [3:0] b2, input logic [11:0] d2);
    return {op, len, b1, d1, b2, d2};
  endfunction

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbA = a; tbD = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic runOp(input logic [47:0] w);
    int n;
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R7 done seen", int'(done), 1);
  endtask

  // R4 R3 R2: plain move of 8 bytes
  task automatic tMove();
    int r0;
    for (int i = 0; i < 8; i++) poke(12'h320 + 12'(i), 8'h30 + 8'(i));
    for (int i = 0; i < 9; i++) poke(12'h110 + 12'(i), 8'hEE);
    r0 = rdCount;
    runOp(mk(8'h01, 8'd7, 4'd3, 12'h010, 4'd4, 12'h020));
    for (int i = 0; i < 8; i++)
      check(mem[12'h110 + 12'(i)] == 8'h30 + 8'(i), "R4 move byte", int'(mem[12'h110 + 12'(i)]), 'h30 + i);
    check(mem[12'h118] == 8'hEE, "R3 byte past end untouched", int'(mem[12'h118]), 'hEE);
    check(rdCount - r0 == 8, "R3 move read count", rdCount - r0, 8);
    check(rdLog[r0[5:0]] == 24'h000320, "R2 first source address", int'(rdLog[r0[5:0]]), 'h320);
  endtask

  // R3: length field zero moves one byte
  task automatic tLenZero();
    poke(12'h330, 8'h5A); poke(12'h140, 8'h00); poke(12'h141, 8'h00);
    runOp(mk(8'h01, 8'd0, 4'd3, 12'h040, 4'd4, 12'h030));
    check(mem[12'h140] == 8'h5A, "R3 single byte copied", int'(mem[12'h140]), 'h5A);
    check(mem[12'h141] == 8'h00, "R3 second byte untouched", int'(mem[12'h141]), 0);
  endtask

  // R4: overlapping destination one above source
  task automatic tOverlap();
    poke(12'h200, 8'h77);
    for (int i = 1; i < 6; i++) poke(12'h200 + 12'(i), 8'h10 + 8'(i));
    runOp(mk(8'h01, 8'd3, 4'd7, 12'h201, 4'd7, 12'h200));
    for (int i = 1; i < 5; i++)
      check(mem[12'h200 + 12'(i)] == 8'h77, "R4 forward propagation", int'(mem[12'h200 + 12'(i)]), 'h77);
    check(mem[12'h205] == 8'h15, "R4 overlap end", int'(mem[12'h205]), 'h15);
  endtask

  // R2: selector zero and upper register bits
  task automatic tAddr();
    int r0;
    poke(12'h040, 8'h9C); poke(12'h050, 8'h00);
    runOp(mk(8'h01, 8'd0, 4'd0, 12'h050, 4'd0, 12'h040));
    check(mem[12'h050] == 8'h9C, "R2 selector zero means base 0", int'(mem[12'h050]), 'h9C);
    r0 = rdCount;
    runOp(mk(8'h01, 8'd0, 4'd3, 12'h0F0, 4'd6, 12'h010));
    check(rdLog[r0[5:0]] == 24'h000210, "R2 address kept to 24 bits", int'(rdLog[r0[5:0]]), 'h210);
  endtask

  // R9: wrap across the top of the address space
  task automatic tWrap();
    int r0;
    poke(12'hFFE, 8'hA1); poke(12'hFFF, 8'hA2); poke(12'h000, 8'hA3); poke(12'h001, 8'hA4);
    r0 = rdCount;
    runOp(mk(8'h01, 8'd3, 4'd3, 12'h080, 4'd5, 12'h000));
    check(rdLog[(r0 + 1) & 63] == 24'hFFFFFF, "R9 address before wrap", int'(rdLog[(r0 + 1) & 63]), 'hFFFFFF);
    check(rdLog[(r0 + 2) & 63] == 24'h000000, "R9 address wraps to zero", int'(rdLog[(r0 + 2) & 63]), 0);
    check(mem[12'h183] == 8'hA4, "R9 data after wrap", int'(mem[12'h183]), 'hA4);
  endtask

  // R5: compare; k < 0 means all equal
  task automatic tCmp(input int n, input int k, input bit aHigh, input string tag);
    int r0, expCc, expRd;
    for (int i = 0; i < n; i++) begin
      poke(12'h400 + 12'(i), 8'h40 + 8'(i));
      if (i == k) poke(12'h500 + 12'(i), aHigh ? 8'h3F + 8'(i) : 8'h41 + 8'(i));
      else        poke(12'h500 + 12'(i), 8'h40 + 8'(i));
    end
    r0 = rdCount;
    runOp(mk(8'h02, 8'(n - 1), 4'd7, 12'h400, 4'd7, 12'h500));
    expCc = (k < 0) ? 0 : (aHigh ? 2 : 1);
    expRd = (k < 0) ? 2 * n : 2 * (k + 1);
    check(cc == 2'(expCc), {"R5 cc ", tag}, int'(cc), expCc);
    check(rdCount - r0 == expRd, {"R5 reads ", tag}, rdCount - r0, expRd);
  endtask

  // R6: move after a compare keeps the condition code
  task automatic tMoveKeepsCc();
    tCmp(3, 1, 1'b1, "high before move");
    poke(12'h330, 8'h01);
    runOp(mk(8'h01, 8'd0, 4'd3, 12'h060, 4'd4, 12'h030));
    check(cc == 2'd2, "R6 move leaves cc", int'(cc), 2);
  endtask

  // R1: unknown opcode ignored
  task automatic tBadOp();
    int r0;
    r0 = rdCount;
    @(negedge clk);
    instr = mk(8'h55, 8'd3, 4'd3, 12'h000, 4'd4, 12'h000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R1 busy stays low", int'(busy), 0);
    repeat (10) @(negedge clk);
    check(rdCount == r0, "R1 no access for unknown opcode", rdCount - r0, 0);
  endtask

  // R7: start while busy ignored; done lasts one cycle
  task automatic tBusyStart();
    int r0, d0;
    for (int i = 0; i < 6; i++) poke(12'h600 + 12'(i), 8'hC0 + 8'(i));
    r0 = rdCount; d0 = doneCount;
    @(negedge clk);
    instr = mk(8'h01, 8'd5, 4'd7, 12'h700, 4'd7, 12'h600); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R7 busy after start", int'(busy), 1);
    repeat (3) @(negedge clk);
    instr = mk(8'h02, 8'd5, 4'd7, 12'h700, 4'd7, 12'h600); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R7 done one cycle", int'(done), 0);
    check(!busy, "R7 busy low after done", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(doneCount - d0 == 1, "R7 second start ignored", doneCount - d0, 1);
    check(rdCount - r0 == 6, "R7 reads of single move", rdCount - r0, 6);
    check(mem[12'h705] == 8'hC5, "R8 data from delayed read", int'(mem[12'h705]), 'hC5);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; instr = '0;
    for (int i = 0; i < 16; i++) regFile[i] = 32'h0;
    regFile[0] = 32'h0000_0500;
    regFile[3] = 32'h0000_0100;
    regFile[4] = 32'h0000_0300;
    regFile[5] = 32'h00FF_FFFE;
    regFile[6] = 32'hAB00_0200;
    regFile[7] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R7 reset idle", int'({busy, done}), 0);
    check(cc == 2'd0, "R5 reset cc", int'(cc), 0);
    check(!memRd && !memWr, "R8 reset no access", int'({memRd, memWr}), 0);
    tMove();
    tLenZero();
    tOverlap();
    tAddr();
    tWrap();
    tCmp(5, -1, 1'b0, "equal");
    tCmp(6, 2, 1'b0, "first lower");
    tCmp(6, 0, 1'b1, "first higher at byte 0");
    tCmp(4, 3, 1'b1, "mismatch on last byte");
    tMoveKeepsCc();
    tBadOp();
    tBusyStart();
    check(clashCount == 0, "R8 no read-write clash", clashCount, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule